// File: doc/BRIEF.md
# Correctable-Fault Address Repeat Filter

This block sits between several memory-fault reporters and the interrupt path. Each reporter hands in the byte address of a correctable fault. The address goes into a small queue that belongs to that reporter. A round-robin arbiter takes one queued address per cycle and checks it against a table of sixteen remembered fault addresses.

A known address is discarded quietly. An unknown address is written into the lowest free slot of the table, and that slot is marked in use. When the reporting source has its enable bit set, the block also raises a one-cycle event that gives the source and the slot. Because a repeat produces nothing, a software loop that keeps touching one bad word cannot flood the processor with notifications.

Software can read any slot and can free one through a single-index clear port. When the table is full, a new unknown address cannot be stored. In that case a sticky overflow flag is set and, if the source is enabled, an event is raised that is marked as a full-table event. Each queue also keeps its own sticky overflow flag for pushes it had to drop.

Top module: `ce_dedup_cam`

## Requirements
- R1: Address bits [2:0] take no part in matching. Two addresses that differ only in those bits are treated as the same fault, and the stored address reads back with bits [2:0] equal to zero.
- R2: An address that matches an occupied slot is discarded. It raises no event and leaves the occupancy vector unchanged.
- R3: An unmatched address is written into the lowest-numbered free slot, and that slot's bit in `occ_o` goes high. At most one slot is filled per cycle, and `rd_addr_o`/`rd_occ_o` return the contents of the slot selected by `rd_idx_i`.
- R4: An event (`evt_o` high for one cycle, with `evt_src_o` and `evt_idx_o`) is raised only when `evt_en_i` of the serviced source was high. It appears at the second rising edge after the push is sampled.
- R5: An unmatched address from a source whose enable is low is still stored, but no event is raised for it.
- R6: An unmatched address that arrives while all 16 slots are occupied is not stored and sets the sticky `cam_ovf_o`. If the source is enabled, it raises an event with `evt_full_o` high.
- R7: Queues are serviced round-robin, one address per cycle. The search starts at the source after the last one granted, and source 0 is first after reset.
- R8: Each source queue holds 4 addresses. A push that arrives while the queue is full and not being popped is dropped, and it sets that source's sticky bit in `fifo_ovf_o`.
- R9: `clr_valid_i` frees slot `clr_idx_i`. If the same slot is allocated in the same cycle, the allocation wins and the slot stays occupied.
- R10: After reset, no slot is occupied, both overflow flags are clear and `evt_o` is low.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flt_valid_i | input | N_SRC | Per-source fault address push |
| flt_addr_i | input | N_SRC x ADDR_W | Per-source fault byte address |
| evt_en_i | input | N_SRC | Per-source event enable |
| clr_valid_i | input | 1 | Free one slot |
| clr_idx_i | input | 4 | Slot to free |
| rd_idx_i | input | 4 | Slot to read |
| rd_addr_o | output | ADDR_W | Stored address of the selected slot, bits [2:0] zero |
| rd_occ_o | output | 1 | Occupied bit of the selected slot |
| occ_o | output | 16 | Occupancy vector |
| evt_o | output | 1 | Event pulse |
| evt_src_o | output | 1 | Source that caused the event |
| evt_idx_o | output | 4 | Slot filled (zero on a full-table event) |
| evt_full_o | output | 1 | Event came from a full table |
| fifo_ovf_o | output | N_SRC | Sticky per-queue overflow |
| cam_ovf_o | output | 1 | Sticky table overflow |

## Verification
The assertions assume that the enable bits seen at an event are those registered one cycle earlier. They also assume that clears and allocations act only through the ports, so any gain in occupancy comes from the single allocation path. The stimulus drives every input at the falling edge, so each change is sampled cleanly at one rising edge. Simultaneous pushes are made only into empty queues, which lets the reference model predict the round-robin order. The queue-overflow burst is run only after the table is full and all enables are low, so it adds no events that the scoreboard would have to order.

// File: rtl/ce_dedup_pkg.sv
package ce_dedup_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_DROP = 2'd1,
    LK_NEW  = 2'd2,
    LK_FULL = 2'd3
  } lookup_res_e;
endpackage

// File: rtl/ce_dedup_fifo.sv
module ce_dedup_fifo #(
  parameter int W     = 29,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] dout_o,
  output logic         ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             accept, do_pop;

  assign do_pop  = pop_i && (cnt_q != '0);
  // space is freed by a same-cycle pop
  assign accept  = push_i && ((cnt_q != CNT_W'(DEPTH)) || do_pop);
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rd_q];
  assign ovf_o   = ovf_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (accept) wr_q <= ptr_inc(wr_q);
      if (do_pop) rd_q <= ptr_inc(rd_q);
      case ({accept, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && !accept) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ce_dedup_rr_arb.sv
module ce_dedup_rr_arb #(
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last_q) + k) % N;
      if (!gnt_valid_o && req_i[j]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_q <= IDX_W'(N - 1);
    else if (gnt_valid_o) last_q <= gnt_idx_o;
  end
endmodule

// File: rtl/ce_dedup_table.sv
module ce_dedup_table
  import ce_dedup_pkg::*;
#(
  parameter int TAG_W = 29,
  parameter int N_ENT = 16,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output lookup_res_e      res_o,
  output logic [IDX_W-1:0] alloc_idx_o,
  input  logic             clr_valid_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [N_ENT-1:0] occ_o
);
  logic [TAG_W-1:0] tag_q [N_ENT];
  logic [N_ENT-1:0] occ_q;
  logic             hit, free_found;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    hit        = 1'b0;
    free_found = 1'b0;
    free_idx   = '0;
    for (int e = 0; e < N_ENT; e++) begin
      if (occ_q[e] && (tag_q[e] == lk_tag_i)) hit = 1'b1;
      if (!occ_q[e] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(e);
      end
    end
    if (!lk_valid_i)     res_o = LK_IDLE;
    else if (hit)        res_o = LK_DROP;
    else if (free_found) res_o = LK_NEW;
    else                 res_o = LK_FULL;
  end

  assign alloc_idx_o = free_idx;
  assign occ_o       = occ_q;
  assign rd_tag_o    = tag_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      for (int e = 0; e < N_ENT; e++) tag_q[e] <= '0;
    end else begin
      for (int e = 0; e < N_ENT; e++) begin
        if ((res_o == LK_NEW) && (free_idx == IDX_W'(e))) begin
          occ_q[e] <= 1'b1;
          tag_q[e] <= lk_tag_i;
        end else if (clr_valid_i && (clr_idx_i == IDX_W'(e))) begin
          occ_q[e] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ce_dedup_cam.sv
module ce_dedup_cam
  import ce_dedup_pkg::*;
#(
  parameter int N_SRC      = 2,
  parameter int ADDR_W     = 32,
  parameter int N_ENT      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int SRC_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  parameter int IDX_W      = $clog2(N_ENT)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_SRC-1:0]              flt_valid_i,
  input  logic [N_SRC-1:0][ADDR_W-1:0]  flt_addr_i,
  input  logic [N_SRC-1:0]              evt_en_i,
  input  logic                          clr_valid_i,
  input  logic [IDX_W-1:0]              clr_idx_i,
  input  logic [IDX_W-1:0]              rd_idx_i,
  output logic [ADDR_W-1:0]             rd_addr_o,
  output logic                          rd_occ_o,
  output logic [N_ENT-1:0]              occ_o,
  output logic                          evt_o,
  output logic [SRC_W-1:0]              evt_src_o,
  output logic [IDX_W-1:0]              evt_idx_o,
  output logic                          evt_full_o,
  output logic [N_SRC-1:0]              fifo_ovf_o,
  output logic                          cam_ovf_o
);
  localparam int TAG_W = ADDR_W - 3;

  logic [N_SRC-1:0]             q_empty;
  logic [N_SRC-1:0]             q_pop;
  logic [N_SRC-1:0][TAG_W-1:0]  q_head;
  logic [N_SRC-1:0]             addr_lsb_unused;
  logic                         gnt_valid;
  logic [SRC_W-1:0]             gnt_idx;
  lookup_res_e                  lk_res;
  logic [IDX_W-1:0]             alloc_idx;
  logic [TAG_W-1:0]             rd_tag;
  logic                         fire;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    // 64-bit alignment: byte offset never enters the table
    assign addr_lsb_unused[s] = ^flt_addr_i[s][2:0];
    assign q_pop[s]           = gnt_valid && (gnt_idx == SRC_W'(s));

    ce_dedup_fifo #(.W(TAG_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (flt_valid_i[s]),
      .din_i   (flt_addr_i[s][ADDR_W-1:3]),
      .pop_i   (q_pop[s]),
      .empty_o (q_empty[s]),
      .dout_o  (q_head[s]),
      .ovf_o   (fifo_ovf_o[s])
    );
  end

  ce_dedup_rr_arb #(.N(N_SRC), .IDX_W(SRC_W)) i_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (~q_empty),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  ce_dedup_table #(.TAG_W(TAG_W), .N_ENT(N_ENT), .IDX_W(IDX_W)) i_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_valid_i  (gnt_valid),
    .lk_tag_i    (q_head[gnt_idx]),
    .res_o       (lk_res),
    .alloc_idx_o (alloc_idx),
    .clr_valid_i (clr_valid_i),
    .clr_idx_i   (clr_idx_i),
    .rd_idx_i    (rd_idx_i),
    .rd_tag_o    (rd_tag),
    .occ_o       (occ_o)
  );

  assign rd_addr_o = {rd_tag, 3'b000};
  assign rd_occ_o  = occ_o[rd_idx_i];
  assign fire      = ((lk_res == LK_NEW) || (lk_res == LK_FULL)) && evt_en_i[gnt_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o      <= 1'b0;
      evt_src_o  <= '0;
      evt_idx_o  <= '0;
      evt_full_o <= 1'b0;
      cam_ovf_o  <= 1'b0;
    end else begin
      evt_o      <= fire;
      evt_src_o  <= fire ? gnt_idx : '0;
      evt_idx_o  <= (fire && (lk_res == LK_NEW)) ? alloc_idx : '0;
      evt_full_o <= fire && (lk_res == LK_FULL);
      if (lk_res == LK_FULL) cam_ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ce_dedup_cam_chk.sv
module ce_dedup_cam_chk #(
  parameter int N_SRC = 2,
  parameter int N_ENT = 16,
  parameter int SRC_W = 1,
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] evt_en_i,
  input logic             clr_valid_i,
  input logic [IDX_W-1:0] clr_idx_i,
  input logic [N_ENT-1:0] occ_o,
  input logic             evt_o,
  input logic [SRC_W-1:0] evt_src_o,
  input logic [IDX_W-1:0] evt_idx_o,
  input logic             evt_full_o,
  input logic [N_SRC-1:0] fifo_ovf_o,
  input logic             cam_ovf_o
);
  logic [N_SRC-1:0] en_d;
  logic [N_ENT-1:0] occ_d;
  logic             clr_v_d;
  logic [IDX_W-1:0] clr_i_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d    <= '0;
      occ_d   <= '0;
      clr_v_d <= 1'b0;
      clr_i_d <= '0;
    end else begin
      en_d    <= evt_en_i;
      occ_d   <= occ_o;
      clr_v_d <= clr_valid_i;
      clr_i_d <= clr_idx_i;
    end
  end

  AST_EVT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> en_d[evt_src_o]); // R4
  AST_NEW_OCCUPIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !evt_full_o) |-> occ_o[evt_idx_o]); // R3
  AST_NEW_WAS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !evt_full_o) |-> !occ_d[evt_idx_o]); // R2
  AST_ONE_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(occ_o & ~occ_d) <= 1); // R3
  AST_FULL_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && evt_full_o) |-> (&occ_d && cam_ovf_o)); // R6
  AST_CAM_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cam_ovf_o) |-> cam_ovf_o); // R6
  AST_FIFO_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_ovf_o & $past(fifo_ovf_o)) == $past(fifo_ovf_o)); // R8
  AST_CLR_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_v_d && occ_d[clr_i_d]) |-> !occ_o[clr_i_d]); // R9
endmodule

bind ce_dedup_cam ce_dedup_cam_chk #(
  .N_SRC(N_SRC), .N_ENT(N_ENT), .SRC_W(SRC_W), .IDX_W(IDX_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_en_i    (evt_en_i),
  .clr_valid_i (clr_valid_i),
  .clr_idx_i   (clr_idx_i),
  .occ_o       (occ_o),
  .evt_o       (evt_o),
  .evt_src_o   (evt_src_o),
  .evt_idx_o   (evt_idx_o),
  .evt_full_o  (evt_full_o),
  .fifo_ovf_o  (fifo_ovf_o),
  .cam_ovf_o   (cam_ovf_o)
);

// File: tb/test_ce_dedup_cam.sv
`timescale 1ns/1ps
module test_ce_dedup_cam;
  localparam int N_SRC = 2, ADDR_W = 32, N_ENT = 16, SRC_W = 1, IDX_W = 4;

  logic                         clk_i = 1'b0;
  logic                         rst_ni = 1'b0;
  logic [N_SRC-1:0]             flt_valid_i = '0;
  logic [N_SRC-1:0][ADDR_W-1:0] flt_addr_i = '0;
  logic [N_SRC-1:0]             evt_en_i = '0;
  logic                         clr_valid_i = 1'b0;
  logic [IDX_W-1:0]             clr_idx_i = '0;
  logic [IDX_W-1:0]             rd_idx_i = '0;
  logic [ADDR_W-1:0]            rd_addr_o;
  logic                         rd_occ_o;
  logic [N_ENT-1:0]             occ_o;
  logic                         evt_o;
  logic [SRC_W-1:0]             evt_src_o;
  logic [IDX_W-1:0]             evt_idx_o;
  logic                         evt_full_o;
  logic [N_SRC-1:0]             fifo_ovf_o;
  logic                         cam_ovf_o;

  always #4 clk_i = ~clk_i;

  ce_dedup_cam i_ce_dedup_cam (.*);

  int checks = 0, fails = 0;
  int exp_q[$];
  logic [ADDR_W-4:0] m_tag [N_ENT];
  logic [N_ENT-1:0]  m_occ = '0;
  int                m_last = N_SRC - 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference model: one serviced address
  task automatic model(input int src, input logic [ADDR_W-1:0] addr);
    logic [ADDR_W-4:0] t;
    int free;
    t = addr[ADDR_W-1:3];
    m_last = src;
    for (int e = 0; e < N_ENT; e++) if (m_occ[e] && m_tag[e] == t) return;
    free = -1;
    for (int e = N_ENT - 1; e >= 0; e--) if (!m_occ[e]) free = e;
    if (free < 0) begin
      if (evt_en_i[src]) exp_q.push_back((1 << 8) | (src << 4));
    end else begin
      m_occ[free] = 1'b1;
      m_tag[free] = t;
      if (evt_en_i[src]) exp_q.push_back((src << 4) | free);
    end
  endtask

  task automatic push_one(input int src, input logic [ADDR_W-1:0] addr);
    @(negedge clk_i);
    flt_valid_i[src] = 1'b1;
    flt_addr_i[src]  = addr;
    model(src, addr);
    @(negedge clk_i);
    flt_valid_i = '0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic push_two(input logic [ADDR_W-1:0] a0, input logic [ADDR_W-1:0] a1);
    int first;
    first = (m_last + 1) % N_SRC;
    @(negedge clk_i);
    flt_valid_i = '1;
    flt_addr_i[0] = a0;
    flt_addr_i[1] = a1;
    model(first, first == 0 ? a0 : a1);
    model(1 - first, first == 0 ? a1 : a0);
    @(negedge clk_i);
    flt_valid_i = '0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic read_chk(input int idx, input logic [ADDR_W-1:0] ea, input bit eo, input string req);
    @(negedge clk_i);
    rd_idx_i = IDX_W'(idx);
    #1;
    chk(rd_occ_o == eo, req, rd_occ_o, eo);
    if (eo) chk(rd_addr_o == ea, req, rd_addr_o, ea);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && evt_o) begin
      int act, exp;
      act = (int'(evt_full_o) << 8) | (int'(evt_src_o) << 4) | int'(evt_idx_o);
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected event", act, 0);
      else begin
        exp = exp_q.pop_front();
        chk(act == exp, "R3/R4/R6/R7 event", act, exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, f;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(occ_o == '0, "R10 occ", occ_o, 0);
    chk(!cam_ovf_o && fifo_ovf_o == '0, "R10 flags", {fifo_ovf_o, cam_ovf_o}, 0);
    chk(!evt_o, "R10 evt", evt_o, 0);

    evt_en_i = '1;
    // R4 latency: event at second edge after push sample
    @(negedge clk_i);
    flt_valid_i[0] = 1'b1;
    flt_addr_i[0] = 32'h0000_1000;
    model(0, 32'h0000_1000);
    @(negedge clk_i);
    flt_valid_i = '0;
    chk(!evt_o, "R4 early", evt_o, 0);
    @(negedge clk_i);
    chk(evt_o, "R4 latency", evt_o, 1);
    repeat (2) @(negedge clk_i);
    read_chk(0, 32'h0000_1000, 1'b1, "R3 read slot0");

    // R1 / R2: differs only in low bits, dropped
    push_one(1, 32'h0000_1005);
    chk(occ_o == 16'h0001, "R2 occ unchanged", occ_o, 1);
    read_chk(1, 0, 1'b0, "R1 slot1 free");

    push_one(1, 32'h0000_2007);
    read_chk(1, 32'h0000_2000, 1'b1, "R1 aligned readback");

    // R5: disabled source still stores
    evt_en_i = 2'b01;
    push_one(1, 32'h0000_3000);
    chk(occ_o == 16'h0007, "R5 stored silently", occ_o, 7);
    evt_en_i = '1;

    // R7 round-robin, both orders
    push_two(32'h0000_4000, 32'h0000_5000);
    push_one(0, 32'h0000_6000);
    push_two(32'h0000_7000, 32'h0000_8000);
    chk(occ_o == 16'h00ff, "R7 eight slots", occ_o, 16'hff);

    // R9 clear, then lowest free reuse
    @(negedge clk_i);
    clr_valid_i = 1'b1;
    clr_idx_i = 4'd1;
    m_occ[1] = 1'b0;
    @(negedge clk_i);
    clr_valid_i = 1'b0;
    chk(occ_o == 16'h00fd, "R9 cleared", occ_o, 16'hfd);
    push_one(0, 32'h0000_9000);
    read_chk(1, 32'h0000_9000, 1'b1, "R3 lowest free reused");

    // R9 clear and allocate same slot: allocate wins
    f = 8;
    @(negedge clk_i);
    flt_valid_i[1] = 1'b1;
    flt_addr_i[1] = 32'h0000_A000;
    model(1, 32'h0000_A000);
    @(negedge clk_i);
    flt_valid_i = '0;
    clr_valid_i = 1'b1;
    clr_idx_i = IDX_W'(f);
    @(negedge clk_i);
    clr_valid_i = 1'b0;
    chk(occ_o[f], "R9 alloc priority", occ_o, 16'h01ff);
    repeat (2) @(negedge clk_i);

    // fill table
    n = 0;
    while (m_occ != '1) begin
      push_one(n % 2, 32'h0010_0000 + n * 8);
      n++;
    end
    chk(occ_o == '1, "R3 full", occ_o, 16'hffff);
    chk(!cam_ovf_o, "R6 no ovf yet", cam_ovf_o, 0);
    push_one(1, 32'h00F0_0000);
    chk(cam_ovf_o, "R6 cam ovf", cam_ovf_o, 1);
    push_one(0, 32'h0000_1000);
    chk(occ_o == '1 && cam_ovf_o, "R2 dup on full", occ_o, 16'hffff);

    // R8 queue overflow
    evt_en_i = '0;
    @(negedge clk_i);
    flt_valid_i = '1;
    repeat (2) @(negedge clk_i);
    flt_valid_i = '0;
    repeat (6) @(negedge clk_i);
    chk(fifo_ovf_o == '0, "R8 no ovf short burst", fifo_ovf_o, 0);
    flt_valid_i = '1;
    repeat (14) @(negedge clk_i);
    flt_valid_i = '0;
    repeat (20) @(negedge clk_i);
    chk(fifo_ovf_o == 2'b11, "R8 sticky ovf", fifo_ovf_o, 3);
    chk(exp_q.size() == 0, "R4 all events seen", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule